// File: doc/BRIEF.md
# Flux Interval to Bit-Cell Decoder

This block sits behind a floppy read channel. It receives the time between two successive flux reversals as a count of sample-clock ticks. It decides how many bit cells that interval covers and then sends the matching bits out serially: a run of zeros followed by a single one that stands for the reversal. The decision is made against a running estimate of the cell period. That estimate follows slow drive-speed drift, but each step is only a fraction of the error and the estimate is held inside a fixed band around nominal. Together these keep intervals that lie far from the ideal multiples, or close to a decision boundary, on the correct side.

The default configuration uses 16-bit tick counts from a 24 MHz sample clock. At that rate the nominal 2 µs cell is 48 ticks. The cell estimate is stored in fixed point with 8 fractional bits. The result is always clamped to the cell counts that MFM permits, 2 to 4. When a clamp is applied, a sticky range flag is set.

Intervals enter through a valid/ready pair. The cell count of each accepted interval is shown for one cycle together with the updated estimate. The bit stream leaves through its own valid/ready pair at one bit per clock.

Top module: `flux_cell_decoder`

## Requirements
- R1: While reset is held, and after it is released, `in_ready` is 1, `bit_valid`, `cell_stb` and `range_err` are 0, and `est_out` equals the nominal estimate NOM_TICKS·2^FRAC (12288 by default).
- R2: An accepted interval of T ticks with estimate E gives the cell count floor((T·512 + E)/(2·E)), which is T·256/E rounded with exact halves going up, clamped to the range MIN_CELLS..MAX_CELLS (2..4).
- R3: `range_err` becomes 1 when an accepted interval rounds to fewer than MIN_CELLS or more than MAX_CELLS cells, and it stays 1 until reset.
- R4: An interval of n cells produces n bits on the bit port, first n−1 zeros and then a one. One bit moves on each clock with `bit_valid` and `bit_ready` both high. `bit_data` holds steady while `bit_ready` is low.
- R5: `in_ready` stays 0 while bits of the previous interval remain to be sent. An interval offered during that time is not taken: no `cell_stb` pulse and no change of estimate.
- R6: With each accepted interval the estimate becomes E + floor((floor(T·256/n) − E)/16), where n is the clamped cell count.
- R7: The estimate is limited to [floor(nominal·88/100), floor(nominal·112/100)], which is [10813, 13762] by default.
- R8: `cell_stb` pulses for exactly one cycle, the cycle after an interval is accepted. `cell_count` and the updated `est_out` are valid in that cycle.
- R9: The jittered interval sequence for the clock word 0x24a5 (3,3,3,2,3,2 cells) produces exactly the 16 bits 0010010010100101 for every group of six intervals. This includes the 119-tick versus 98-tick pair, which must decode to 3 and 2 cells.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Interval offered |
| in_ready | output | 1 | Interval can be taken (serializer empty) |
| in_ticks | input | IW | Interval length in ticks |
| cell_stb | output | 1 | One-cycle strobe for a new cell count |
| cell_count | output | CNT_W | Cells of the last accepted interval |
| est_out | output | IW+FRAC | Current cell estimate, fixed point |
| range_err | output | 1 | Sticky clamp flag |
| bit_valid | output | 1 | A bit is present on bit_data |
| bit_ready | input | 1 | Downstream accepts a bit |
| bit_data | output | 1 | Serial decoded bit |

## Verification
The assertions assume that `in_ticks` is stable and known whenever `in_valid` is high. They also assume that the downstream side may stall with `bit_ready` for any length of time without the design dropping or changing a bit. The stimulus drives inputs only on the falling edge and holds an offered interval until it is taken. It stalls the bit port only in a dedicated phase. It keeps every interval inside the 16-bit range, so the quotient and the estimate path never wrap.

// File: rtl/fdec_pkg.sv
package fdec_pkg;

  // clamp outcome of one quantization
  typedef struct packed {
    logic below;
    logic above;
  } fdec_clip_t;

  // scale a value by a percentage, integer floor
  function automatic int fdec_pct(input int base, input int pct);
    return (base * pct) / 100;
  endfunction

endpackage

// File: rtl/fdec_rst_sync.sv
module fdec_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/fdec_quantizer.sv
module fdec_quantizer
  import fdec_pkg::*;
#(
  parameter int IW        = 16,
  parameter int FRAC      = 8,
  parameter int MIN_CELLS = 2,
  parameter int MAX_CELLS = 4,
  parameter int CNT_W     = $clog2(MAX_CELLS + 1)
) (
  input  logic [IW-1:0]      ticks,
  input  logic [IW+FRAC-1:0] est,
  output logic [CNT_W-1:0]   cells,
  output fdec_clip_t         clip
);

  localparam int EW = IW + FRAC;
  localparam int CW = EW + 5;
  localparam int NB = MAX_CELLS - MIN_CELLS;
  localparam int LO_MULT = 2 * MIN_CELLS - 1;
  localparam int HI_MULT = 2 * MAX_CELLS + 1;

  // interval scaled by 2^(FRAC+1): compare against (2k+1)*est for k+0.5 cells
  logic [CW-1:0] lhs;
  logic [CW-1:0] est_w;
  logic [NB-1:0] crossed;

  assign lhs   = CW'({ticks, {FRAC{1'b0}}, 1'b0});
  assign est_w = CW'(est);

  for (genvar k = 0; k < NB; k++) begin : g_bound
    localparam int MULT = 2 * (MIN_CELLS + k) + 1;
    assign crossed[k] = (lhs >= est_w * CW'(MULT));
  end

  assign clip.below = (lhs < est_w * CW'(LO_MULT));
  assign clip.above = (lhs >= est_w * CW'(HI_MULT));

  // thresholds are monotonic, so the count of crossed ones is the clamped result
  always_comb begin
    cells = CNT_W'(MIN_CELLS);
    for (int i = 0; i < NB; i++) begin
      cells = cells + CNT_W'(crossed[i]);
    end
  end

endmodule

// File: rtl/fdec_tracker.sv
module fdec_tracker #(
  parameter int IW         = 16,
  parameter int FRAC       = 8,
  parameter int CNT_W      = 3,
  parameter int GAIN_SHIFT = 4,
  parameter int EST_RST    = 12288,
  parameter int EST_LO     = 10813,
  parameter int EST_HI     = 13762
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                upd_en,
  input  logic [IW-1:0]       ticks,
  input  logic [CNT_W-1:0]    cells,
  output logic [IW+FRAC-1:0]  est
);

  localparam int EW = IW + FRAC;
  localparam int SW = EW + 2;

  logic [EW-1:0]        est_q;
  logic [EW-1:0]        est_d;
  logic [EW-1:0]        target;
  logic signed [SW-1:0] err;
  logic signed [SW-1:0] step;
  logic signed [SW-1:0] sum;

  // per-cell period implied by this interval
  assign target = EW'({ticks, {FRAC{1'b0}}}) / EW'(cells);

  always_comb begin
    err  = $signed({2'b00, target}) - $signed({2'b00, est_q});
    step = err >>> GAIN_SHIFT;
    sum  = $signed({2'b00, est_q}) + step;
    est_d = est_q;
    if (upd_en) begin
      if (sum < $signed(SW'(EST_LO))) begin
        est_d = EW'(EST_LO);
      end else if (sum > $signed(SW'(EST_HI))) begin
        est_d = EW'(EST_HI);
      end else begin
        est_d = sum[EW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      est_q <= EW'(EST_RST);
    end else if (upd_en) begin
      est_q <= est_d;
    end
  end

  assign est = est_q;

  a_r7_est_in_band: assert property (@(posedge clk) disable iff (!rst_n)
    (est_q >= EW'(EST_LO)) && (est_q <= EW'(EST_HI)));

  a_r5_est_held_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(est_q));

endmodule

// File: rtl/fdec_serializer.sv
module fdec_serializer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_cells,
  input  logic             bit_ready,
  output logic             bit_valid,
  output logic             bit_data,
  output logic             idle
);

  logic [CNT_W-1:0] rem_q;
  logic [CNT_W-1:0] rem_d;
  logic             rem_en;
  logic             shift;

  assign shift = bit_valid & bit_ready;

  always_comb begin
    rem_d  = rem_q;
    rem_en = 1'b0;
    if (load_en) begin
      rem_d  = load_cells;
      rem_en = 1'b1;
    end else if (shift) begin
      rem_d  = rem_q - CNT_W'(1);
      rem_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (rem_en) begin
      rem_q <= rem_d;
    end
  end

  assign bit_valid = (rem_q != '0);
  assign bit_data  = (rem_q == CNT_W'(1));
  assign idle      = (rem_q == '0);

  a_r4_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !bit_ready) |=> (bit_valid && $stable(bit_data)));

  a_r4_one_ends_interval: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && bit_ready && bit_data) |=> !bit_valid);

  a_r4_zero_continues: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && bit_ready && !bit_data) |=> bit_valid);

endmodule

// File: rtl/flux_cell_decoder.sv
module flux_cell_decoder
  import fdec_pkg::*;
#(
  parameter int IW         = 16,
  parameter int FRAC       = 8,
  parameter int NOM_TICKS  = 48,
  parameter int TOL_PCT    = 12,
  parameter int GAIN_SHIFT = 4,
  parameter int MIN_CELLS  = 2,
  parameter int MAX_CELLS  = 4,
  parameter int CNT_W      = $clog2(MAX_CELLS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [IW-1:0]      in_ticks,
  output logic               cell_stb,
  output logic [CNT_W-1:0]   cell_count,
  output logic [IW+FRAC-1:0] est_out,
  output logic               range_err,
  output logic               bit_valid,
  input  logic               bit_ready,
  output logic               bit_data
);

  localparam int EW      = IW + FRAC;
  localparam int EST_NOM = NOM_TICKS * (2 ** FRAC);
  localparam int EST_LO  = fdec_pct(EST_NOM, 100 - TOL_PCT);
  localparam int EST_HI  = fdec_pct(EST_NOM, 100 + TOL_PCT);

  logic             rst_i;
  logic             accept;
  logic             ser_idle;
  logic [CNT_W-1:0] q_cells;
  fdec_clip_t       q_clip;
  logic [EW-1:0]    est;

  logic             stb_q, stb_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             err_q, err_d;
  logic             err_en;

  fdec_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_i)
  );

  assign in_ready = ser_idle;
  assign accept   = in_valid & ser_idle;

  fdec_quantizer #(
    .IW        (IW),
    .FRAC      (FRAC),
    .MIN_CELLS (MIN_CELLS),
    .MAX_CELLS (MAX_CELLS),
    .CNT_W     (CNT_W)
  ) u_quant (
    .ticks (in_ticks),
    .est   (est),
    .cells (q_cells),
    .clip  (q_clip)
  );

  fdec_tracker #(
    .IW         (IW),
    .FRAC       (FRAC),
    .CNT_W      (CNT_W),
    .GAIN_SHIFT (GAIN_SHIFT),
    .EST_RST    (EST_NOM),
    .EST_LO     (EST_LO),
    .EST_HI     (EST_HI)
  ) u_track (
    .clk    (clk),
    .rst_n  (rst_i),
    .upd_en (accept),
    .ticks  (in_ticks),
    .cells  (q_cells),
    .est    (est)
  );

  fdec_serializer #(
    .CNT_W (CNT_W)
  ) u_ser (
    .clk        (clk),
    .rst_n      (rst_i),
    .load_en    (accept),
    .load_cells (q_cells),
    .bit_ready  (bit_ready),
    .bit_valid  (bit_valid),
    .bit_data   (bit_data),
    .idle       (ser_idle)
  );

  // count strobe, count register and sticky clamp flag
  always_comb begin
    stb_d  = accept;
    cnt_d  = q_cells;
    cnt_en = accept;
    err_d  = err_q | q_clip.below | q_clip.above;
    err_en = accept;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      stb_q <= 1'b0;
    end else begin
      stb_q <= stb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      cnt_q <= CNT_W'(MIN_CELLS);
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      err_q <= 1'b0;
    end else if (err_en) begin
      err_q <= err_d;
    end
  end

  assign cell_stb   = stb_q;
  assign cell_count = cnt_q;
  assign range_err  = err_q;
  assign est_out    = est;

  a_r8_stb_follows_accept: assert property (@(posedge clk) disable iff (!rst_i)
    accept |=> cell_stb);

  a_r8_stb_single: assert property (@(posedge clk) disable iff (!rst_i)
    cell_stb |=> !cell_stb);

  a_r2_count_legal: assert property (@(posedge clk) disable iff (!rst_i)
    cell_stb |-> (cell_count >= CNT_W'(MIN_CELLS)) && (cell_count <= CNT_W'(MAX_CELLS)));

  a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rst_i)
    range_err |=> range_err);

  a_r5_load_brings_bits: assert property (@(posedge clk) disable iff (!rst_i)
    accept |=> (bit_valid && !in_ready));

endmodule

// File: tb/tb_flux_cell_decoder.sv
module tb_flux_cell_decoder;

  localparam int IW = 16;
  localparam int FRAC = 8;
  localparam int EW = IW + FRAC;
  localparam int CNT_W = 3;
  localparam int NOM = 48 * 256;
  localparam int LO = (NOM * 88) / 100;
  localparam int HI = (NOM * 112) / 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [IW-1:0] in_ticks = '0;
  logic cell_stb;
  logic [CNT_W-1:0] cell_count;
  logic [EW-1:0] est_out;
  logic range_err;
  logic bit_valid;
  logic bit_ready = 1'b1;
  logic bit_data;

  int n_checks = 0;
  int n_fail = 0;
  int m_est = NOM;
  bit exp_q[$];
  bit word_on = 1'b0;
  logic [15:0] word_sr = '0;
  int word_cnt = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  flux_cell_decoder dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_ticks(in_ticks), .cell_stb(cell_stb), .cell_count(cell_count),
    .est_out(est_out), .range_err(range_err), .bit_valid(bit_valid),
    .bit_ready(bit_ready), .bit_data(bit_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // bit monitor: compares each transferred bit with the model (R4, R9)
  always @(negedge clk) begin
    cyc++;
    if (rst_n && bit_valid && bit_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected bit", int'(bit_data), -1);
      end else begin
        bit e;
        e = exp_q.pop_front();
        check(bit_data == e, "R4 bit order", int'(bit_data), int'(e));
      end
      if (word_on) begin
        word_sr = {word_sr[14:0], bit_data};
        word_cnt++;
        if (word_cnt == 16) begin
          check(word_sr == 16'h24a5, "R9 clock word", int'(word_sr), 16'h24a5);
          word_cnt = 0;
        end
      end
    end
  end

  // watchdog
  initial begin
    #(5 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks + 1, n_fail);
    $finish;
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    exp_q.delete();
    m_est = NOM;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  function automatic int model_cells(input int t, input int e, output bit clipped);
    int raw;
    raw = (t * 512 + e) / (2 * e);
    clipped = (raw < 2) || (raw > 4);
    if (raw < 2) raw = 2;
    if (raw > 4) raw = 4;
    return raw;
  endfunction

  // offer one interval, wait for acceptance, check the strobe cycle (R2, R6, R7, R8)
  task automatic send(input int t, output int n, output bit clipped);
    int tgt;
    int stp;
    @(negedge clk);
    in_valid = 1'b1;
    in_ticks = IW'(t);
    while (!in_ready) @(negedge clk);
    n = model_cells(t, m_est, clipped);
    tgt = (t * 256) / n;
    stp = (tgt - m_est) >>> 4;
    m_est = m_est + stp;
    if (m_est < LO) m_est = LO;
    if (m_est > HI) m_est = HI;
    for (int i = 1; i < n; i++) exp_q.push_back(1'b0);
    exp_q.push_back(1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    check(cell_stb == 1'b1, "R8 strobe", int'(cell_stb), 1);
    check(int'(cell_count) == n, "R2 cell count", int'(cell_count), n);
    check(int'(est_out) == m_est, "R6 estimate update", int'(est_out), m_est);
    @(negedge clk);
    check(cell_stb == 1'b0, "R8 strobe width", int'(cell_stb), 0);
  endtask

  task automatic drain();
    while (!in_ready || exp_q.size() != 0) @(negedge clk);
  endtask

  int tbl[18] = '{126,131,126,96,121,98, 125,131,126,97,120,98, 124,132,126,98,119,98};
  int truth[6] = '{3,3,3,2,3,2};

  initial begin
    int n;
    bit clp;
    // R1: reset state, during and after reset
    repeat (2) @(negedge clk);
    check(in_ready == 1'b1 && bit_valid == 1'b0, "R1 ready/valid in reset", int'({in_ready, bit_valid}), 2);
    do_reset();
    check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    check(bit_valid == 1'b0, "R1 bit_valid", int'(bit_valid), 0);
    check(cell_stb == 1'b0, "R1 cell_stb", int'(cell_stb), 0);
    check(range_err == 1'b0, "R1 range_err", int'(range_err), 0);
    check(int'(est_out) == NOM, "R1 estimate", int'(est_out), NOM);

    // R2, R3: sweep every interval 0..255 from the nominal estimate
    for (int t = 0; t < 256; t++) begin
      do_reset();
      send(t, n, clp);
      check(range_err == clp, "R3 clamp flag", int'(range_err), int'(clp));
      drain();
    end

    // R3: flag stays set across later in-range intervals
    do_reset();
    send(300, n, clp);
    check(range_err == 1'b1, "R3 flag set", int'(range_err), 1);
    for (int i = 0; i < 4; i++) send(144, n, clp);
    drain();
    check(range_err == 1'b1, "R3 flag sticky", int'(range_err), 1);

    // R4, R5: stall the bit port, offer an interval that must not be taken
    do_reset();
    bit_ready = 1'b0;
    send(144, n, clp);
    check(n == 3, "R2 nominal three cells", n, 3);
    in_valid = 1'b1;
    in_ticks = IW'(200);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(in_ready == 1'b0, "R5 ready low while busy", int'(in_ready), 0);
      check(bit_valid == 1'b1 && bit_data == 1'b0, "R4 held first zero", int'(bit_data), 0);
      check(cell_stb == 1'b0, "R5 no strobe while busy", int'(cell_stb), 0);
    end
    in_valid = 1'b0;
    check(int'(est_out) == m_est, "R5 estimate unchanged", int'(est_out), m_est);
    @(negedge clk);
    bit_ready = 1'b1;
    drain();
    check(exp_q.size() == 0, "R4 all bits sent", exp_q.size(), 0);

    // R7: drive the estimate to the upper and lower limits
    do_reset();
    for (int i = 0; i < 40; i++) send(240, n, clp);
    drain();
    check(int'(est_out) == HI, "R7 upper limit", int'(est_out), HI);
    do_reset();
    for (int i = 0; i < 60; i++) send(120, n, clp);
    drain();
    check(int'(est_out) == LO, "R7 lower limit", int'(est_out), LO);

    // R9: jittered clock-word table, repeated
    do_reset();
    word_on = 1'b1;
    word_cnt = 0;
    for (int r = 0; r < 40; r++) begin
      for (int j = 0; j < 18; j++) begin
        send(tbl[j], n, clp);
        check(n == truth[j % 6], "R9 table cells", n, truth[j % 6]);
      end
    end
    drain();
    word_on = 1'b0;
    check(word_cnt == 0, "R9 whole words", word_cnt, 0);
    check(range_err == 1'b0, "R9 no clamp on table", int'(range_err), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule